// File: doc/BRIEF.md
# Shared Modular-Multiplier Self-Test Engine

This block wraps one single-cycle modular multiplier (x*y mod P) with two operand multiplexers and a small sequencer, so that the same arithmetic unit serves three purposes. When idle it behaves as an ordinary multiplier for a host: operands and a modulus go in, and the reduced product comes out one cycle later. During a self-test it alternates between two jobs. In a pattern cycle it squares its previous output, producing a pseudorandom stimulus word for an external circuit under test. In a compaction cycle it multiplies a running signature by the response that circuit returned, folding that response into the signature.

A test is launched with a single-cycle start pulse. In that cycle the block captures the modulus, the expected (golden) signature, the seed, the initial signature and the number of patterns. After the last response it raises done and reports pass when the final signature equals the golden value. The circuit under test and the transport of its data lie outside the block. The response input is sampled in the cycle in which a fresh pattern is presented, so a combinational circuit under test, or one with a matching wrapper, can be attached directly.

Top module: `bist_mm_top`

## Requirements
- R1: While no test runs and start_i is low, a mul_req_i pulse with op_a_i, op_b_i and modulus_i gives res_valid_o high in the next cycle, with res_o = (op_a_i*op_b_i) mod modulus_i, where the modulus must be at least 2.
- R2: A mul_req_i raised while busy_o is high, or in the same cycle as start_i, is ignored: res_valid_o stays low and res_o keeps its previous value.
- R3: A start_i pulse while idle or done captures seed_i, and a zero seed is replaced by 1. Pattern k (k = 1..N) is x_k = x_(k-1)^2 mod P, where x_0 is the captured seed and P is the modulus captured at start. The seed should be below P.
- R4: The captured initial signature follows the same zero-to-1 rule. After each pattern k the signature becomes s_k = s_(k-1)*r_k mod P, where r_k is cut_resp_i in the cycle in which pattern k is shown.
- R5: A test with N = pat_count_i > 0 keeps busy_o high for exactly 2N cycles, starting the cycle after start_i. pattern_valid_o is high on every second of those cycles and never on two cycles in a row, and pattern_o is stable while it is high.
- R6: After the last compaction, done_o is high with busy_o low, signature_o holds s_N, and pass_o is high exactly when s_N equals the golden value captured at start. pass_o is never high without done_o.
- R7: Every product written to res_o, pattern_o or signature_o by the multiplier is strictly below the modulus in use. A product that is an exact multiple of P gives 0.
- R8: With pat_count_i = 0, done_o rises in the cycle after start_i, with no pattern shown and signature_o equal to the captured initial signature.
- R9: A start_i pulse while busy_o is high is ignored, and the running test completes with its original parameters.
- R10: After reset, busy_o, done_o, pass_o, pattern_valid_o and res_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a self-test (single-cycle pulse) |
| pat_count_i | input | CW | Number of patterns N, captured at start |
| modulus_i | input | W | Modulus; captured at start, used directly for host multiplies |
| golden_i | input | W | Expected final signature, captured at start |
| seed_i | input | W | Pattern seed, captured at start |
| sig_init_i | input | W | Initial signature, captured at start |
| mul_req_i | input | 1 | Host multiply request |
| op_a_i | input | W | Host operand A |
| op_b_i | input | W | Host operand B |
| cut_resp_i | input | W | Response of the circuit under test |
| pattern_o | output | W | Current pseudorandom pattern |
| pattern_valid_o | output | 1 | A fresh pattern is shown and the response is sampled this cycle |
| res_o | output | W | Host multiply result |
| res_valid_o | output | 1 | res_o was updated in the previous cycle |
| signature_o | output | W | Running or final signature |
| busy_o | output | 1 | Self-test in progress |
| done_o | output | 1 | Self-test finished |
| pass_o | output | 1 | Final signature matches golden |

## Verification
The checker watches on every cycle that host results and shown patterns stay below the modulus, and that a request raised while busy produces no result. It also checks that pattern_valid_o never repeats on consecutive cycles, that a shown pattern holds steady, and that pass and done never contradict busy. Only the bench's scenarios can show the values themselves: the squaring chain from a given seed, the signature product over a modelled response sequence, the exact 2N busy length, the zero-count and zero-seed cases, and that a start pulse in the middle of a run leaves the result untouched.

// File: rtl/bist_mm_pkg.sv
package bist_mm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PAT,
    ST_SIG,
    ST_DONE
  } bist_state_e;

  typedef enum logic [1:0] {
    OP_HOST,
    OP_SQUARE,
    OP_COMPACT
  } op_sel_e;
endpackage

// File: rtl/bist_modmul.sv
module bist_modmul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] m_i,
  output logic [W-1:0] r_o
);
  localparam int PW = 2 * W;

  // Full product followed by a true remainder, so the result is always below m.
  function automatic logic [W-1:0] mod_mul(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic [W-1:0] m);
    logic [PW-1:0] prod;
    logic [PW-1:0] rem;
    if (m == '0) return '0;
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    rem  = prod % {{W{1'b0}}, m};
    return rem[W-1:0];
  endfunction

  assign r_o = mod_mul(a_i, b_i, m_i);
endmodule

// File: rtl/bist_opmux.sv
module bist_opmux
  import bist_mm_pkg::*;
#(
  parameter int W = 32
) (
  input  op_sel_e      sel_i,
  input  logic [W-1:0] host_a_i,
  input  logic [W-1:0] host_b_i,
  input  logic [W-1:0] pat_i,
  input  logic [W-1:0] sig_i,
  input  logic [W-1:0] resp_i,
  output logic [W-1:0] opnd_x_o,
  output logic [W-1:0] opnd_y_o
);
  localparam int LANES = 2;

  logic [LANES-1:0][W-1:0] host_src;
  logic [LANES-1:0][W-1:0] cmp_src;
  logic [LANES-1:0][W-1:0] lane_out;

  assign host_src = {host_b_i, host_a_i};
  assign cmp_src  = {resp_i, sig_i};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [W-1:0] pick;
    always_comb begin
      unique case (sel_i)
        OP_SQUARE:  pick = pat_i;
        OP_COMPACT: pick = cmp_src[l];
        default:    pick = host_src[l];
      endcase
    end
    assign lane_out[l] = pick;
  end

  assign opnd_x_o = lane_out[0];
  assign opnd_y_o = lane_out[1];
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_mm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mul_req_i,
  input  logic [CW-1:0] pat_count_i,
  output bist_state_e   state_o,
  output logic          load_o,
  output logic          mul_fire_o,
  output logic          busy_o,
  output logic          done_o
);
  bist_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, pc_q;
  logic          idle_like, last_pat;

  assign idle_like  = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign load_o     = idle_like && start_i;
  assign mul_fire_o = idle_like && mul_req_i && !start_i;
  assign last_pat   = (cnt_q == (pc_q - CW'(1)));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = (pat_count_i == '0) ? ST_DONE : ST_PAT;
      ST_PAT:           state_d = ST_SIG;
      ST_SIG:           state_d = last_pat ? ST_DONE : ST_PAT;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        cnt_q <= '0;
        pc_q  <= pat_count_i;
      end else if (state_q == ST_SIG) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign state_o = state_q;
  assign busy_o  = (state_q == ST_PAT) || (state_q == ST_SIG);
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/bist_mm_top.sv
module bist_mm_top
  import bist_mm_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] pat_count_i,
  input  logic [W-1:0]  modulus_i,
  input  logic [W-1:0]  golden_i,
  input  logic [W-1:0]  seed_i,
  input  logic [W-1:0]  sig_init_i,
  input  logic          mul_req_i,
  input  logic [W-1:0]  op_a_i,
  input  logic [W-1:0]  op_b_i,
  input  logic [W-1:0]  cut_resp_i,
  output logic [W-1:0]  pattern_o,
  output logic          pattern_valid_o,
  output logic [W-1:0]  res_o,
  output logic          res_valid_o,
  output logic [W-1:0]  signature_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o
);
  function automatic logic [W-1:0] nonzero(input logic [W-1:0] v);
    return (v == '0) ? W'(1) : v;
  endfunction

  bist_state_e  state;
  op_sel_e      op_sel;
  logic         load, mul_fire, busy, done;
  logic [W-1:0] p_q, golden_q, x_q, sig_q, res_q;
  logic         res_valid_q;
  logic [W-1:0] opnd_x, opnd_y, mod_sel, prod;

  bist_ctrl #(.CW(CW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mul_req_i   (mul_req_i),
    .pat_count_i (pat_count_i),
    .state_o     (state),
    .load_o      (load),
    .mul_fire_o  (mul_fire),
    .busy_o      (busy),
    .done_o      (done)
  );

  always_comb begin
    unique case (state)
      ST_PAT:  op_sel = OP_SQUARE;
      ST_SIG:  op_sel = OP_COMPACT;
      default: op_sel = OP_HOST;
    endcase
  end

  assign mod_sel = busy ? p_q : modulus_i;

  bist_opmux #(.W(W)) u_mux (
    .sel_i    (op_sel),
    .host_a_i (op_a_i),
    .host_b_i (op_b_i),
    .pat_i    (x_q),
    .sig_i    (sig_q),
    .resp_i   (cut_resp_i),
    .opnd_x_o (opnd_x),
    .opnd_y_o (opnd_y)
  );

  bist_modmul #(.W(W)) u_mul (
    .a_i (opnd_x),
    .b_i (opnd_y),
    .m_i (mod_sel),
    .r_o (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q         <= '0;
      golden_q    <= '0;
      x_q         <= '0;
      sig_q       <= '0;
      res_q       <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= mul_fire;
      if (mul_fire) res_q <= prod;
      if (load) begin
        p_q      <= modulus_i;
        golden_q <= golden_i;
        x_q      <= nonzero(seed_i);
        sig_q    <= nonzero(sig_init_i);
      end else if (state == ST_PAT) begin
        x_q <= prod;
      end else if (state == ST_SIG) begin
        sig_q <= prod;
      end
    end
  end

  assign pattern_o       = x_q;
  assign pattern_valid_o = (state == ST_SIG);
  assign res_o           = res_q;
  assign res_valid_o     = res_valid_q;
  assign signature_o     = sig_q;
  assign busy_o          = busy;
  assign done_o          = done;
  assign pass_o          = done && (sig_q == golden_q);
endmodule

// File: rtl/bist_mm_chk.sv
module bist_mm_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         mul_req,
  input logic [W-1:0] modulus,
  input logic [W-1:0] p_cap,
  input logic         busy,
  input logic         done,
  input logic         pass,
  input logic         res_valid,
  input logic [W-1:0] res,
  input logic         pattern_valid,
  input logic [W-1:0] pattern
);
  AST_HOST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_req && !busy && !start) |=> res_valid); // R1

  AST_BUSY_REQ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_req && busy) |=> (!res_valid && $stable(res))); // R2

  AST_PATTERN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_valid |=> $stable(pattern)); // R5

  AST_PV_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_valid |=> !pattern_valid); // R5

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && !busy)); // R6

  AST_RES_BELOW_P: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (($past(modulus) == '0) || (res < $past(modulus)))); // R7

  AST_PATTERN_BELOW_P: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_valid |-> (pattern < p_cap)); // R7
endmodule

bind bist_mm_top bist_mm_chk #(.W(W)) u_chk (
  .clk           (clk_i),
  .rst_n         (rst_ni),
  .start         (start_i),
  .mul_req       (mul_req_i),
  .modulus       (modulus_i),
  .p_cap         (p_q),
  .busy          (busy_o),
  .done          (done_o),
  .pass          (pass_o),
  .res_valid     (res_valid_o),
  .res           (res_o),
  .pattern_valid (pattern_valid_o),
  .pattern       (pattern_o)
);

// File: tb/bist_mm_top_bench.sv
`timescale 1ns/1ps
module bist_mm_top_bench;
  localparam int W  = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] pat_count = '0;
  logic [W-1:0]  modulus = '0, golden = '0, seed = '0, sig_init = '0;
  logic          mul_req = 1'b0;
  logic [W-1:0]  op_a = '0, op_b = '0, cut_resp = '0;
  logic [W-1:0]  pattern, res, signature;
  logic          pattern_valid, res_valid, busy, done, pass;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bist_mm_top #(.W(W), .CW(CW)) u_bist_mm_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pat_count_i(pat_count),
    .modulus_i(modulus), .golden_i(golden), .seed_i(seed), .sig_init_i(sig_init),
    .mul_req_i(mul_req), .op_a_i(op_a), .op_b_i(op_b), .cut_resp_i(cut_resp),
    .pattern_o(pattern), .pattern_valid_o(pattern_valid), .res_o(res),
    .res_valid_o(res_valid), .signature_o(signature), .busy_o(busy),
    .done_o(done), .pass_o(pass)
  );

  // Shift-and-add modular multiply, independent of a wide product.
  function automatic logic [W-1:0] ref_mm(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [W-1:0] p);
    logic [W:0] r, aa;
    aa = {1'b0, a % p};
    r  = '0;
    for (int i = W - 1; i >= 0; i--) begin
      r = r << 1;
      if (r >= {1'b0, p}) r = r - {1'b0, p};
      if (b[i]) begin
        r = r + aa;
        if (r >= {1'b0, p}) r = r - {1'b0, p};
      end
    end
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] nz(input logic [W-1:0] v);
    return (v == 0) ? 1 : v;
  endfunction

  // Behavioural model of the circuit under test.
  function automatic logic [W-1:0] cut_model(input logic [W-1:0] v);
    return {v[W-6:0], v[W-1:W-5]} ^ 32'h3C96_A51F;
  endfunction

  function automatic logic [W-1:0] ref_sig(input logic [W-1:0] p, input logic [W-1:0] s0,
                                           input logic [W-1:0] i0, input int n);
    logic [W-1:0] x, s;
    x = nz(s0);
    s = nz(i0);
    for (int k = 0; k < n; k++) begin
      x = ref_mm(x, x, p);
      s = ref_mm(s, cut_model(x), p);
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] p, input string tag);
    @(negedge clk);
    mul_req = 1'b1; op_a = a; op_b = b; modulus = p;
    @(negedge clk);
    mul_req = 1'b0;
    modulus = $urandom;
    chk(res_valid == 1'b1, {tag, " valid"}, W'(res_valid), 1);
    chk(res == ref_mm(a, b, p), tag, res, ref_mm(a, b, p));
  endtask

  task automatic run_test(input logic [W-1:0] p, input logic [W-1:0] s0,
                          input logic [W-1:0] i0, input int n,
                          input bit good, input bit disturb);
    logic [W-1:0] exp_sig, gold, bx, bs, res_keep;
    exp_sig = ref_sig(p, s0, i0, n);
    gold = good ? exp_sig : (exp_sig ^ 32'h1);
    bx = nz(s0);
    bs = nz(i0);
    @(negedge clk);
    start = 1'b1; modulus = p; golden = gold; seed = s0; sig_init = i0;
    pat_count = CW'(n);
    @(negedge clk);
    start = 1'b0;
    modulus = $urandom; golden = $urandom; seed = $urandom; sig_init = $urandom;
    pat_count = CW'($urandom);
    for (int k = 0; k < n; k++) begin
      chk(busy && !pattern_valid && !done, "R5 pattern cycle busy", W'(busy), 1);
      if (disturb && k == 1) begin
        res_keep = res;
        start = 1'b1;   // R9: must be ignored
        mul_req = 1'b1; // R2: must be ignored
        op_a = 32'h1234_5678; op_b = 32'h9ABC_DEF0;
      end
      @(negedge clk);
      if (disturb && k == 1) begin
        start = 1'b0; mul_req = 1'b0;
        chk(!res_valid && res == res_keep, "R2 busy request dropped", res, res_keep);
      end
      bx = ref_mm(bx, bx, p);
      chk(busy && pattern_valid, "R5 compaction cycle flags", W'(pattern_valid), 1);
      chk(pattern == bx, "R3 pattern value", pattern, bx);
      chk(pattern < p, "R7 pattern below modulus", pattern, p);
      cut_resp = cut_model(bx);
      bs = ref_mm(bs, cut_model(bx), p);
      @(negedge clk);
      cut_resp = $urandom;
    end
    chk(done && !busy, "R6 done after 2N cycles", W'(done), 1);
    chk(!pattern_valid, "R6 no pattern when done", W'(pattern_valid), 0);
    chk(signature == exp_sig && signature == bs, "R4 final signature", signature, exp_sig);
    chk(pass == good, "R6 pass flag", W'(pass), W'(good));
    if (disturb) chk(signature == exp_sig, "R9 start during run ignored", signature, exp_sig);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !pattern_valid && !res_valid, "R10 reset state",
        {27'b0, busy, done, pass, pattern_valid, res_valid}, 0);
    rst_n = 1'b1;

    // R1 / R7 directed corners
    host_mul(32'd1000003, 32'd77, 32'd1000003, "R7 exact multiple gives zero");
    host_mul(32'd2000006, 32'hFFFF_FFFF, 32'd1000003, "R7 double multiple gives zero");
    host_mul(32'hFFFF_FFFA, 32'hFFFF_FFFA, 32'hFFFF_FFFB, "R1 (P-1)^2 mod P");
    host_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 operand equal to modulus");
    for (int i = 0; i < 100; i++) begin
      logic [W-1:0] pr;
      pr = $urandom | 32'h2;
      host_mul($urandom, $urandom, pr, "R1 random host multiply");
    end

    // R8 zero pattern count
    run_test(32'd101, 32'd5, 32'd9, 0, 1'b1, 1'b0);
    chk(signature == 32'd9, "R8 zero count keeps init", signature, 32'd9);

    // R3 / R4 small directed case
    run_test(32'd101, 32'd3, 32'd7, 3, 1'b1, 1'b0);
    // R3 / R4 zero seed and zero init replaced by 1, golden mismatch
    run_test(32'd65521, 32'd0, 32'd0, 5, 1'b0, 1'b0);
    // R9 / R2 random modulus with disturbance
    run_test($urandom | 32'h8000_0001, $urandom_range(2, 1000), $urandom_range(2, 1000),
             40, 1'b1, 1'b1);
    // long run at the largest prime below 2^32
    run_test(32'hFFFF_FFFB, 32'hDEAD_BEEF, 32'h0BAD_F00D, 2534, 1'b1, 1'b0);

    // R1 host multiply allowed after done, done stays
    host_mul(32'd12345, 32'd67890, 32'd99991, "R1 multiply while done");
    chk(done, "R6 done held after host multiply", W'(done), 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule